// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a serial peripheral bus master that software drives through five 32-bit registers on a simple single-cycle register bus. Software picks clock polarity, clock phase, bit order and loopback in a control register, fills a transmit FIFO with words, and clears a hold bit to let the shift engine run. For each word sent, one word is captured from the serial input and queued in a receive FIFO for software to drain.

The word width, the serial clock half-period (in system clocks), the FIFO depth and the number of select lines are fixed by parameters. Active-low select lines come from a select register and are either driven continuously (manual) or only while a word is on the wire (automatic). With loopback set, the serial output feeds the receiver directly, so software can write a known pattern and read it back, for example to find out the byte order of the bus.

Top module: `spi_host_ctrl`

## Requirements
- R1: The control register is at offset 0x60 with bits: 0 loopback, 1 enable, 2 master, 3 clock polarity, 4 clock phase, 5 transmit FIFO clear, 6 receive FIFO clear, 7 manual select, 8 hold, 9 LSB first. It resets to 0x100 and reads back what was written, except that bits 5 and 6 always read 0.
- R2: The status register at 0x64 reads bit 0 receive empty, bit 1 receive full, bit 2 transmit empty, bit 3 transmit full; all other bits read 0.
- R3: A write to 0x68 queues the low WORD_W bits in the transmit FIFO; a write while it holds FIFO_DEPTH words is discarded.
- R4: A read of 0x6C returns the oldest received word (zero-extended) and removes it; a read while the receive FIFO is empty returns 0 and leaves the FIFO unchanged.
- R5: A word starts shifting only when enable and master are 1, hold is 0 and the transmit FIFO is not empty; otherwise the serial clock does not toggle.
- R6: Writing 1 to control bit 5 empties the transmit FIFO, writing 1 to bit 6 empties the receive FIFO.
- R7: The serial clock rests at the polarity bit. With phase 0 the input is sampled on the first (leading) edge of each bit and the output changes on the trailing edge; with phase 1 the output changes on the leading edge and the input is sampled on the trailing edge.
- R8: Bits go out and come in most significant first; with control bit 9 set, least significant first.
- R9: Each transmitted word produces exactly 2*WORD_W serial clock edges, SCK_DIV system clocks apart, and exactly one received word.
- R10: With loopback set, the receiver takes the serial output and the external serial input is ignored.
- R11: The select register at 0x70 resets to all ones; with manual select the lines equal the register at all times, otherwise they equal it only while a word is shifting and are all ones in between.
- R12: A received word that completes while the receive FIFO is full is dropped, and `rx_overrun` pulses high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | NUM_SS | Active-low select lines |
| rx_overrun | output | 1 | Pulse when a received word is dropped |

## Verification
The bench builds the block with 8-bit words, a serial half-period of two system clocks, four-entry FIFOs and four select lines. The short FIFOs make full, overflow and overrun reachable with a few words, and the short words and fast clock let the bench sweep all four clock modes in both bit orders against a bit-level slave model. Loopback runs with the external input tied high, so any leak of it shows up in the received words.

// File: rtl/spi_host_pkg.sv
// Shared constants of the SPI master: register offsets and control bit positions.
// Assumes byte offsets on an 8-bit address, 32-bit data.
package spi_host_pkg;
    localparam int CB_LOOP   = 0;
    localparam int CB_EN     = 1;
    localparam int CB_MASTER = 2;
    localparam int CB_CPOL   = 3;
    localparam int CB_CPHA   = 4;
    localparam int CB_TXCLR  = 5;
    localparam int CB_RXCLR  = 6;
    localparam int CB_MANUAL = 7;
    localparam int CB_HOLD   = 8;
    localparam int CB_LSB    = 9;
    localparam int CTRL_W    = 10;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 10'h100;

    localparam logic [7:0] OFS_CTRL = 8'h60;
    localparam logic [7:0] OFS_STAT = 8'h64;
    localparam logic [7:0] OFS_TXD  = 8'h68;
    localparam logic [7:0] OFS_RXD  = 8'h6C;
    localparam logic [7:0] OFS_SSEL = 8'h70;
endpackage

// File: rtl/spi_word_fifo.sv
// Synchronous show-ahead FIFO of words.
// Assumes: push while full and pop while empty are ignored; clr empties it in one cycle.
module spi_word_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy update with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/spi_shift_core.sv
// Serial shift engine: sends one W-bit word and captures one word per start.
// Assumes mode bits are stable during a word; sck idles at cpol; edges are DIV clocks apart.
module spi_shift_core #(
    parameter int W   = 8,
    parameter int DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] word_in,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         lsb_first,
    input  logic         miso,
    output logic         busy,
    output logic         sck,
    output logic         mosi,
    output logic         done,
    output logic [W-1:0] word_out
);
    localparam int DW        = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int EW        = $clog2(2 * W);
    localparam int LAST_EDGE = 2 * W - 1;

    logic [W-1:0]  tx_sr, rx_sr, in_rev, rx_rev;
    logic [DW-1:0] div_cnt;
    logic [EW-1:0] edge_cnt;
    logic          phase;

    // Bit-reversed views used for LSB-first order.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign in_rev[i] = word_in[W-1-i];
        assign rx_rev[i] = rx_sr[W-1-i];
    end

    assign sck      = cpol ^ phase;
    assign mosi     = tx_sr[W-1];
    assign word_out = lsb_first ? rx_rev : rx_sr;

    // Word sequencer: clock divider, edge count, shift and sample per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            phase    <= 1'b0;
            div_cnt  <= '0;
            edge_cnt <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy     <= 1'b1;
                    tx_sr    <= lsb_first ? in_rev : word_in;
                    div_cnt  <= '0;
                    edge_cnt <= '0;
                    phase    <= 1'b0;
                end
            end else if (div_cnt == DW'(DIV - 1)) begin
                div_cnt  <= '0;
                phase    <= ~phase;
                edge_cnt <= edge_cnt + 1'b1;
                if (!phase) begin
                    if (!cpha)               rx_sr <= {rx_sr[W-2:0], miso};
                    else if (edge_cnt != '0) tx_sr <= tx_sr << 1;
                end else begin
                    if (!cpha) tx_sr <= tx_sr << 1;
                    else       rx_sr <= {rx_sr[W-2:0], miso};
                end
                if (edge_cnt == EW'(LAST_EDGE)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_host_ctrl.sv
// Register-mapped SPI master: control, status, data and select registers, two FIFOs
// and one shift engine. Assumes single-cycle bus strobes and WORD_W <= 32.
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int SCK_DIV    = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int NUM_SS     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_SS-1:0] spi_ss_n,
    output logic              rx_overrun
);
    localparam logic [CTRL_W-1:0] CTRL_KEEP = ~((CTRL_W'(1) << CB_TXCLR) | (CTRL_W'(1) << CB_RXCLR));

    logic [CTRL_W-1:0] ctrl_q;
    logic [NUM_SS-1:0] ssr_q;
    logic              wr_ctrl, wr_txd, wr_ssel, rd_rxd;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [WORD_W-1:0] tx_dout, rx_dout, eng_word;
    logic              eng_busy, eng_done, eng_start, miso_int;
    logic              unused_bits;

    assign wr_ctrl     = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_txd      = bus_wr && (bus_addr == OFS_TXD);
    assign wr_ssel     = bus_wr && (bus_addr == OFS_SSEL);
    assign rd_rxd      = bus_rd && (bus_addr == OFS_RXD);
    assign unused_bits = ^bus_wdata;

    // Control and select registers; FIFO clear bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            ssr_q  <= '1;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0] & CTRL_KEEP;
            if (wr_ssel) ssr_q  <= bus_wdata[NUM_SS-1:0];
        end
    end

    assign eng_start = ctrl_q[CB_EN] && ctrl_q[CB_MASTER] && !ctrl_q[CB_HOLD]
                       && !tx_empty && !eng_busy;
    assign miso_int  = ctrl_q[CB_LOOP] ? spi_mosi : spi_miso;

    spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(wr_ctrl && bus_wdata[CB_TXCLR]),
        .push(wr_txd), .din(bus_wdata[WORD_W-1:0]), .pop(eng_start),
        .dout(tx_dout), .empty(tx_empty), .full(tx_full)
    );

    spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(wr_ctrl && bus_wdata[CB_RXCLR]),
        .push(eng_done), .din(eng_word), .pop(rd_rxd),
        .dout(rx_dout), .empty(rx_empty), .full(rx_full)
    );

    spi_shift_core #(.W(WORD_W), .DIV(SCK_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .word_in(tx_dout),
        .cpol(ctrl_q[CB_CPOL]), .cpha(ctrl_q[CB_CPHA]), .lsb_first(ctrl_q[CB_LSB]),
        .miso(miso_int), .busy(eng_busy), .sck(spi_sck), .mosi(spi_mosi),
        .done(eng_done), .word_out(eng_word)
    );

    assign rx_overrun = eng_done && rx_full;
    assign spi_ss_n   = (ctrl_q[CB_MANUAL] || eng_busy) ? ssr_q : '1;

    // Read data mux, combinational in the strobe cycle.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
                OFS_STAT: bus_rdata[3:0] = {tx_full, tx_empty, rx_full, rx_empty};
                OFS_RXD:  if (!rx_empty) bus_rdata[WORD_W-1:0] = rx_dout;
                OFS_SSEL: bus_rdata[NUM_SS-1:0] = ssr_q;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/spi_host_ctrl_chk.sv
// Checker for spi_host_ctrl: temporal properties across engine, FIFOs and outputs.
// Assumes it is attached by the bind below.
module spi_host_ctrl_chk #(
    parameter int NUM_SS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [9:0]        ctrl_q,
    input logic              eng_busy,
    input logic              eng_done,
    input logic              tx_empty,
    input logic              tx_full,
    input logic              rx_empty,
    input logic              rd_rxd,
    input logic              spi_sck,
    input logic [NUM_SS-1:0] spi_ss_n
);
    a_r5_hold_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[8] && !eng_busy) |=> !eng_busy);

    a_r9_done_at_word_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_busy) |-> eng_done);

    a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |-> !eng_busy);

    a_r7_sck_rests_at_cpol: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> (spi_sck == ctrl_q[3]));

    a_r11_auto_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[7] && !eng_busy) |-> (&spi_ss_n));

    a_r4_empty_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxd && rx_empty && !eng_done) |=> rx_empty);

    a_r3_tx_state_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty));
endmodule

bind spi_host_ctrl spi_host_ctrl_chk #(.NUM_SS(NUM_SS)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .eng_busy(eng_busy), .eng_done(eng_done),
    .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rd_rxd(rd_rxd),
    .spi_sck(spi_sck), .spi_ss_n(spi_ss_n)
);

// File: tb/sim_spi_host_ctrl.sv
// Bench: small configuration, mode/order sweep against a bit-level slave model.
module sim_spi_host_ctrl;
    localparam int W = 8, DIV = 2, DEPTH = 4, NSS = 4;
    localparam logic [7:0] A_CTRL = 8'h60, A_STAT = 8'h64, A_TXD = 8'h68, A_RXD = 8'h6C, A_SSEL = 8'h70;
    localparam logic [31:0] LOOP = 32'h1, EN = 32'h2, MST = 32'h4, MAN = 32'h80,
                            HOLD = 32'h100, TXC = 32'h20, RXC = 32'h40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic spi_sck, spi_mosi, spi_miso, rx_overrun;
    logic [NSS-1:0] spi_ss_n;

    int n_chk = 0, n_err = 0;
    int toggles = 0, sfalls = 0, drops = 0, idx = 0;
    logic slave_en = 1'b0, miso_s = 1'b0;
    logic t_cpol = 1'b0, t_cpha = 1'b0, t_lsb = 1'b0;
    logic sck_prev = 1'b0, ss_prev = 1'b1;
    logic [7:0] txw [2];
    logic [7:0] resp_w [2];
    logic [7:0] cap [2];
    logic [31:0] rv;

    always #2 clk = ~clk;

    assign spi_miso = slave_en ? miso_s : 1'b1;

    spi_host_ctrl #(.WORD_W(W), .SCK_DIV(DIV), .FIFO_DEPTH(DEPTH), .NUM_SS(NSS)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_ss_n(spi_ss_n), .rx_overrun(rx_overrun)
    );

    function automatic int bsel(input int i);
        return t_lsb ? i : (W - 1 - i);
    endfunction

    // Slave model and edge/overrun monitors, sampled at the falling clock.
    always @(negedge clk) begin
        if (rx_overrun) drops++;
        if (spi_sck != sck_prev) toggles++;
        if (ss_prev && !spi_ss_n[0]) begin
            sfalls++;
            idx = 0;
            if (!t_cpha && sfalls <= 2) miso_s = resp_w[sfalls-1][bsel(0)];
        end
        if (spi_sck != sck_prev && (!ss_prev || !spi_ss_n[0]) && sfalls >= 1 && sfalls <= 2) begin
            if (spi_sck != t_cpol) begin
                if (!t_cpha) cap[sfalls-1][bsel(idx)] = spi_mosi;
                else if (idx < W) miso_s = resp_w[sfalls-1][bsel(idx)];
            end else begin
                if (!t_cpha) begin
                    idx++;
                    if (idx < W) miso_s = resp_w[sfalls-1][bsel(idx)];
                end else begin
                    if (idx < W) cap[sfalls-1][bsel(idx)] = spi_mosi;
                    idx++;
                end
            end
        end
        sck_prev = spi_sck;
        ss_prev  = spi_ss_n[0];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] w5 [5];
        logic [31:0] base;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        // Reset state
        rd(A_CTRL, rv); chk("R1 reset ctrl", rv, 32'h100);
        rd(A_STAT, rv); chk("R2 reset status", rv, 32'h5);
        rd(A_SSEL, rv); chk("R11 reset select reg", rv, 32'hF);
        chk("R11 reset lines", 32'(spi_ss_n), 32'hF);
        chk("R7 reset sck", 32'(spi_sck), 32'h0);
        // R1 readback with clear bits masked
        wr(A_CTRL, 32'h3FF); rd(A_CTRL, rv); chk("R1 readback", rv, 32'h39F);
        wr(A_CTRL, 32'h0A5 | HOLD); rd(A_CTRL, rv); chk("R1 readback 2", rv, 32'h185);
        // R3/R5 hold: fill past depth with hold set
        wr(A_CTRL, EN | MST | HOLD | TXC | RXC);
        for (int j = 0; j < 5; j++) begin
            w5[j] = 8'(j * 8'h3B + 8'h11);
            wr(A_TXD, 32'hABCD0000 | 32'(w5[j]));
        end
        rd(A_STAT, rv); chk("R2 R3 tx full status", rv, 32'h9);
        @(posedge clk); toggles = 0;
        repeat (60) @(negedge clk);
        chk("R5 hold blocks sck", 32'(toggles), 32'h0);
        wr(A_CTRL, MST | LOOP);
        repeat (60) @(negedge clk);
        chk("R5 disabled blocks sck", 32'(toggles), 32'h0);
        rd(A_STAT, rv); chk("R5 fifo untouched", rv, 32'h9);
        // Release in loopback: only first DEPTH words exist
        wr(A_CTRL, EN | MST | LOOP);
        repeat (200) @(negedge clk);
        for (int j = 0; j < 4; j++) begin
            rd(A_RXD, rv); chk("R3 R4 R10 word", rv, 32'(w5[j]));
        end
        rd(A_RXD, rv); chk("R3 R4 empty read zero", rv, 32'h0);
        rd(A_STAT, rv); chk("R4 empty unchanged", rv, 32'h5);
        // R6 FIFO clears
        wr(A_CTRL, EN | MST | LOOP | HOLD);
        wr(A_TXD, 32'h5A); wr(A_TXD, 32'hA5);
        wr(A_CTRL, EN | MST | LOOP | HOLD | TXC);
        rd(A_STAT, rv); chk("R6 tx cleared", rv, 32'h5);
        wr(A_TXD, 32'h77); wr(A_CTRL, EN | MST | LOOP);
        repeat (60) @(negedge clk);
        rd(A_STAT, rv); chk("R6 rx has data", rv, 32'h4);
        wr(A_CTRL, EN | MST | LOOP | RXC);
        rd(A_STAT, rv); chk("R6 rx cleared", rv, 32'h5);
        // R10/R11 manual select, loopback with external input high
        slave_en = 1'b0;
        wr(A_CTRL, LOOP | EN | MST | MAN | HOLD | TXC | RXC);
        wr(A_SSEL, 32'hD);
        chk("R11 manual lines idle", 32'(spi_ss_n), 32'hD);
        for (int j = 0; j < 3; j++) wr(A_TXD, 32'((j * 8'h29 + 8'h40) & 8'hFF));
        wr(A_CTRL, LOOP | EN | MST | MAN);
        repeat (150) @(negedge clk);
        for (int j = 0; j < 3; j++) begin
            rd(A_RXD, rv); chk("R10 loopback ignores miso", rv, 32'((j * 8'h29 + 8'h40) & 8'hFF));
        end
        chk("R11 manual lines after", 32'(spi_ss_n), 32'hD);
        // R12 overrun
        wr(A_CTRL, LOOP | EN | MST | HOLD | TXC | RXC);
        for (int j = 0; j < 4; j++) wr(A_TXD, 32'(8'hC0 + j));
        wr(A_CTRL, LOOP | EN | MST);
        repeat (200) @(negedge clk);
        rd(A_STAT, rv); chk("R2 rx full status", rv, 32'h6);
        chk("R12 no drop yet", 32'(drops), 32'h0);
        wr(A_TXD, 32'hEE);
        repeat (60) @(negedge clk);
        chk("R12 one drop", 32'(drops), 32'h1);
        for (int j = 0; j < 4; j++) begin
            rd(A_RXD, rv); chk("R12 kept words", rv, 32'(8'hC0 + j));
        end
        rd(A_RXD, rv); chk("R12 dropped word absent", rv, 32'h0);
        // R7/R8/R9/R11 sweep: all modes, both orders, slave model
        slave_en = 1'b1;
        for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < 2; l++) begin
                t_cpol = m[1]; t_cpha = m[0]; t_lsb = l[0];
                base = EN | MST | (32'(t_cpol) << 3) | (32'(t_cpha) << 4) | (32'(t_lsb) << 9);
                wr(A_CTRL, base | HOLD | TXC | RXC);
                wr(A_SSEL, 32'hE);
                for (int j = 0; j < 2; j++) begin
                    txw[j]    = 8'(m * 37 + l * 91 + j * 53 + 27);
                    resp_w[j] = txw[j] ^ 8'hC3 ^ 8'(j << 2);
                    cap[j]    = 8'h00;
                    wr(A_TXD, 32'(txw[j]));
                end
                @(posedge clk); toggles = 0; sfalls = 0;
                chk("R7 idle sck level", 32'(spi_sck), 32'(t_cpol));
                wr(A_CTRL, base);
                repeat (120) @(negedge clk);
                for (int j = 0; j < 2; j++) begin
                    rd(A_RXD, rv); chk("R7 R8 R9 received word", rv, 32'(resp_w[j]));
                    chk("R7 R8 slave saw word", 32'(cap[j]), 32'(txw[j]));
                end
                chk("R9 edge count", 32'(toggles), 32'(4 * W));
                chk("R11 auto select per word", 32'(sfalls), 32'h2);
                chk("R11 auto lines idle", 32'(spi_ss_n), 32'hF);
                chk("R7 sck back at rest", 32'(spi_sck), 32'(t_cpol));
            end
        end
        finish_run();
    end
endmodule